// File: doc/BRIEF.md
# Digital PLL Lock Detector

The block judges whether a phase-locked loop has settled by timing the reference and feedback rising edges at its phase-frequency detector. Both edges arrive as single-cycle pulses in a fast sampling clock domain. Each pair of pulses is turned into a gap, counted in sample-clock ticks, and the gap is the same whichever edge came first. A measurement unit pairs the two edges and reports each gap. A qualifier then counts consecutive PFD cycles whose gap falls inside the lock window. When the count reaches a selectable target, the qualifier raises a lock flag.

Once the flag is set, a gap just outside the lock window does not clear it. Only a gap beyond a separate, wider loss-of-lock threshold clears the flag, or a partner edge that never arrives. The flag is also available as an active-low status output. A range input picks one of two window and loss-of-lock threshold sets, a two-bit code picks the run length, and a disable input forces the flag to the unlocked state.

Top module: `pll_lock_det`

## Requirements
- R1: The gap is the absolute tick distance between paired reference and feedback pulses, whichever comes first, with 0 meaning both pulses arrive in the same cycle. A PFD cycle is in-window when its gap is strictly less than the selected window.
- R2: The run of consecutive in-window cycles that sets the lock flag depends on the two-bit code count_sel_i: 00 needs 5 cycles, 01 needs 16, 10 needs 64 and 11 needs 255. One cycle fewer leaves the flag clear. The run counter saturates at the target.
- R3: While the flag is clear, any out-of-window cycle resets the run count to zero, so a full new run is needed.
- R4: While the flag is set, it stays set for every gap up to and including the loss-of-lock threshold. It clears on the first gap greater than that threshold.
- R5: range_low_i = 0 selects the wide range, with window 8 and loss-of-lock threshold 16. range_low_i = 1 selects the narrow range, with window 3 and loss-of-lock threshold 6.
- R6: disable_i = 1 clears the flag and the run count within one clock. While disable_i is 1 the flag stays clear whatever the edges do.
- R7: A first edge whose partner has not arrived within 32 ticks counts as beyond the loss-of-lock threshold. A repeated edge on the same input before the partner arrives counts the same way.
- R8: lock_n_o is the active-low copy of locked_o.
- R9: After reset the flag is clear (locked_o = 0, lock_n_o = 1) and the run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_edge_i | input | 1 | Reference rising-edge pulse, one cycle wide |
| fb_edge_i | input | 1 | Feedback rising-edge pulse, one cycle wide |
| range_low_i | input | 1 | 0 selects the wide window range, 1 the narrow range |
| count_sel_i | input | 2 | Code for the run length needed to declare lock |
| disable_i | input | 1 | 1 forces the flag clear |
| locked_o | output | 1 | Lock flag, active high |
| lock_n_o | output | 1 | Lock status, active low |

## Verification
In both ranges and both edge orders, the bench sweeps every gap from 0 to one tick beyond the loss-of-lock threshold. From the unlocked state, a run of each gap shows exactly where the lock window edge lies. From the locked state, one cycle of each gap shows the hysteresis band and where loss of lock begins.

For each run-length code, the bench sends a run one cycle short and then the full run, which separates the four targets. A run broken by a single out-of-window cycle shows that the count restarts from zero. Missing partner edges, repeated same-side edges and the disable input each have to clear a held lock.

// File: rtl/pll_lock_det_pkg.sv
package pll_lock_det_pkg;
  localparam int unsigned RUN_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REF  = 2'd1,
    ST_FB   = 2'd2
  } pair_st_e;

  function automatic logic [RUN_W-1:0] run_target(input logic [1:0] sel);
    case (sel)
      2'b00:   return RUN_W'(5);
      2'b01:   return RUN_W'(16);
      2'b10:   return RUN_W'(64);
      default: return RUN_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/lock_thresh_sel.sv
module lock_thresh_sel #(
  parameter int unsigned GAP_W     = 6,
  parameter int unsigned WIN_HIGH  = 8,
  parameter int unsigned LOSS_HIGH = 16,
  parameter int unsigned WIN_LOW   = 3,
  parameter int unsigned LOSS_LOW  = 6
) (
  input  logic             range_low_i,
  output logic [GAP_W-1:0] win_o,
  output logic [GAP_W-1:0] loss_o
);
  localparam logic [GAP_W-1:0] WinH  = GAP_W'(WIN_HIGH);
  localparam logic [GAP_W-1:0] LossH = GAP_W'(LOSS_HIGH);
  localparam logic [GAP_W-1:0] WinL  = GAP_W'(WIN_LOW);
  localparam logic [GAP_W-1:0] LossL = GAP_W'(LOSS_LOW);

  assign win_o  = range_low_i ? WinL  : WinH;
  assign loss_o = range_low_i ? LossL : LossH;

  initial begin
    a_loss_gt_win_r5: assert (LOSS_HIGH > WIN_HIGH && LOSS_LOW > WIN_LOW)
      else $error("loss threshold must exceed window");
  end
endmodule

// File: rtl/edge_gap_meas.sv
module edge_gap_meas
  import pll_lock_det_pkg::*;
#(
  parameter int unsigned TIMEOUT = 32,
  parameter int unsigned GAP_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_edge_i,
  input  logic             fb_edge_i,
  output logic             meas_valid_o,
  output logic             meas_miss_o,
  output logic [GAP_W-1:0] meas_gap_o
);
  localparam logic [GAP_W-1:0] Tmo = GAP_W'(TIMEOUT);

  pair_st_e         st_q;
  logic [GAP_W-1:0] tick_q;
  logic             partner, same_side;

  always_comb begin
    partner   = 1'b0;
    same_side = 1'b0;
    case (st_q)
      ST_REF: begin partner = fb_edge_i;  same_side = ref_edge_i; end
      ST_FB:  begin partner = ref_edge_i; same_side = fb_edge_i;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      tick_q       <= '0;
      meas_valid_o <= 1'b0;
      meas_miss_o  <= 1'b0;
      meas_gap_o   <= '0;
    end else begin
      meas_valid_o <= 1'b0;
      meas_miss_o  <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (ref_edge_i && fb_edge_i) begin
          meas_valid_o <= 1'b1;
          meas_gap_o   <= '0;
        end else if (ref_edge_i || fb_edge_i) begin
          st_q   <= ref_edge_i ? ST_REF : ST_FB;
          tick_q <= GAP_W'(1);
        end
      end else if (partner) begin
        meas_valid_o <= 1'b1;
        meas_gap_o   <= tick_q;
        st_q         <= ST_IDLE;
      end else if (same_side) begin
        // repeated edge: old one lost its partner, restart on the new one
        meas_valid_o <= 1'b1;
        meas_miss_o  <= 1'b1;
        meas_gap_o   <= Tmo;
        tick_q       <= GAP_W'(1);
      end else if (tick_q >= Tmo) begin
        meas_valid_o <= 1'b1;
        meas_miss_o  <= 1'b1;
        meas_gap_o   <= Tmo;
        st_q         <= ST_IDLE;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  p_gap_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |-> meas_gap_o <= Tmo);
  p_miss_implies_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_miss_o |-> meas_valid_o);
  p_same_cycle_gap0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && ref_edge_i && fb_edge_i) |=> (meas_valid_o && meas_gap_o == '0));
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import pll_lock_det_pkg::*;
#(
  parameter int unsigned GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_valid_i,
  input  logic             meas_miss_i,
  input  logic [GAP_W-1:0] meas_gap_i,
  input  logic [GAP_W-1:0] win_i,
  input  logic [GAP_W-1:0] loss_i,
  input  logic [1:0]       count_sel_i,
  input  logic             disable_i,
  output logic             locked_o
);
  logic [RUN_W-1:0] run_q, run_nxt, target;
  logic             in_win, beyond_loss;

  assign target      = run_target(count_sel_i);
  assign in_win      = !meas_miss_i && (meas_gap_i < win_i);
  assign beyond_loss = meas_miss_i || (meas_gap_i > loss_i);
  assign run_nxt     = (run_q >= target) ? target : run_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (disable_i) begin
      run_q    <= '0;
      locked_o <= 1'b0;
    end else if (meas_valid_i) begin
      if (!locked_o) begin
        if (in_win) begin
          run_q <= run_nxt;
          if (run_nxt == target) locked_o <= 1'b1;
        end else begin
          run_q <= '0;
        end
      end else if (beyond_loss) begin
        locked_o <= 1'b0;
        run_q    <= '0;
      end
    end else if (run_q > target) begin
      run_q <= target;
    end
  end

  p_disable_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> (!locked_o && run_q == '0));
  p_run_saturates_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(count_sel_i) |-> run_q <= target);
  p_lock_on_inwin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(meas_valid_i && in_win && !disable_i));
  p_unlock_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(disable_i || (meas_valid_i && beyond_loss)));
  p_reset_on_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && meas_valid_i && !in_win && !disable_i) |=> (run_q == '0 && !locked_o));
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned TIMEOUT   = 32,
  parameter int unsigned WIN_HIGH  = 8,
  parameter int unsigned LOSS_HIGH = 16,
  parameter int unsigned WIN_LOW   = 3,
  parameter int unsigned LOSS_LOW  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_edge_i,
  input  logic       fb_edge_i,
  input  logic       range_low_i,
  input  logic [1:0] count_sel_i,
  input  logic       disable_i,
  output logic       locked_o,
  output logic       lock_n_o
);
  localparam int unsigned GAP_W = $clog2(TIMEOUT + 1) + 1;

  logic             meas_valid, meas_miss;
  logic [GAP_W-1:0] meas_gap, win, loss;

  edge_gap_meas #(.TIMEOUT(TIMEOUT), .GAP_W(GAP_W)) u_meas (
    .clk_i, .rst_ni, .ref_edge_i, .fb_edge_i,
    .meas_valid_o(meas_valid), .meas_miss_o(meas_miss), .meas_gap_o(meas_gap)
  );

  lock_thresh_sel #(
    .GAP_W(GAP_W), .WIN_HIGH(WIN_HIGH), .LOSS_HIGH(LOSS_HIGH),
    .WIN_LOW(WIN_LOW), .LOSS_LOW(LOSS_LOW)
  ) u_thr (
    .range_low_i, .win_o(win), .loss_o(loss)
  );

  lock_qualifier #(.GAP_W(GAP_W)) u_qual (
    .clk_i, .rst_ni,
    .meas_valid_i(meas_valid), .meas_miss_i(meas_miss), .meas_gap_i(meas_gap),
    .win_i(win), .loss_i(loss), .count_sel_i, .disable_i, .locked_o
  );

  assign lock_n_o = ~locked_o;

  p_status_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_n_o != locked_o);
endmodule

// File: tb/pll_lock_det_test.sv
module pll_lock_det_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_e = 1'b0, fb_e = 1'b0, rng = 1'b0, dis = 1'b0;
  logic [1:0] csel = 2'b00;
  logic       locked, lock_n;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pll_lock_det uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_e), .fb_edge_i(fb_e),
    .range_low_i(rng), .count_sel_i(csel), .disable_i(dis),
    .locked_o(locked), .lock_n_o(lock_n)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (locked !== exp || lock_n !== ~exp) begin
      n_bad++;
      $display("FAIL %s: locked=%b lock_n=%b expected locked=%b", req, locked, lock_n, exp);
    end
  endtask

  task automatic pair(input int g, input bit fb_first);
    @(negedge clk);
    if (g == 0) begin ref_e = 1'b1; fb_e = 1'b1; end
    else if (fb_first) fb_e = 1'b1;
    else ref_e = 1'b1;
    @(negedge clk);
    ref_e = 1'b0; fb_e = 1'b0;
    if (g > 0) begin
      repeat (g - 1) @(negedge clk);
      if (fb_first) ref_e = 1'b1; else fb_e = 1'b1;
      @(negedge clk);
      ref_e = 1'b0; fb_e = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock();
    @(negedge clk); dis = 1'b1;
    repeat (2) @(negedge clk); dis = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int n, input int g, input bit fbf);
    for (int i = 0; i < n; i++) pair(g, fbf);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int win, loss;
    repeat (3) @(negedge clk);
    check("R9", 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", 1'b0);

    // R1/R4/R5 sweep: both ranges, both orders, every gap to loss+1
    for (int r = 0; r < 2; r++) begin
      rng = r[0];
      win  = r ? 3 : 8;
      loss = r ? 6 : 16;
      for (int o = 0; o < 2; o++) begin
        for (int g = 0; g <= loss + 1; g++) begin
          unlock();
          run(5, g, o[0]);
          check(r ? "R1 R5 low window" : "R1 R5 high window", g < win);
          unlock();
          run(5, 0, o[0]);
          pair(g, o[0]);
          check(r ? "R4 R5 low loss" : "R4 R5 high loss", g <= loss);
        end
      end
    end

    // R2: each run-length code
    rng = 1'b0;
    for (int c = 0; c < 4; c++) begin
      int n;
      n = (c == 0) ? 5 : (c == 1) ? 16 : (c == 2) ? 64 : 255;
      csel = c[1:0];
      unlock();
      run(n - 1, 2, c[0]);
      check("R2 short run", 1'b0);
      pair(2, c[0]);
      check("R2 full run", 1'b1);
    end
    csel = 2'b00;

    // R3: broken run restarts
    unlock();
    run(4, 1, 1'b0);
    pair(8, 1'b0);
    run(4, 1, 1'b0);
    check("R3 restart short", 1'b0);
    pair(1, 1'b0);
    check("R3 restart full", 1'b1);

    // R7: missing partner clears lock
    @(negedge clk); ref_e = 1'b1; @(negedge clk); ref_e = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 before timeout", 1'b1);
    repeat (20) @(negedge clk);
    check("R7 timeout", 1'b0);
    // R7: repeated same-side edge
    run(5, 0, 1'b0);
    check("R7 relock", 1'b1);
    @(negedge clk); fb_e = 1'b1; @(negedge clk); fb_e = 1'b0;
    repeat (2) @(negedge clk); fb_e = 1'b1; @(negedge clk); fb_e = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 repeated edge", 1'b0);
    repeat (40) @(negedge clk);

    // R6: disable clears and holds
    run(5, 0, 1'b0);
    check("R6 locked before", 1'b1);
    @(negedge clk); dis = 1'b1;
    @(negedge clk);
    check("R6 cleared", 1'b0);
    run(6, 0, 1'b0);
    check("R6 held", 1'b0);
    dis = 1'b0;
    run(4, 0, 1'b0);
    check("R6 count cleared", 1'b0);
    pair(0, 1'b0);
    check("R6 relock", 1'b1);
    check("R8", 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule